// File: doc/BRIEF.md
# Return Address Stack with Register Window

This block keeps the return addresses of a small processor core. When the core takes a subroutine call or enters an interrupt it pushes its program counter, and on a return it pops the saved address back. The stack has eight entries of a 12-bit program counter. Its pointer is 4 bits wide and counts downward from all ones. A push stores the value at the slot the pointer selects and then decrements the pointer. A pop increments the pointer and delivers the slot it then selects. A pop directly after a push therefore returns the value just pushed.

The pointer shares one byte register with the global interrupt enable bit. Every stack entry can also be read and written through a byte-wide register bus, using a low byte and a high byte per entry. Software can inspect or patch saved addresses this way, and it resets the stack by writing the pointer back to all ones. The pointer wraps silently. The block raises no overflow or underflow flag and does not arbitrate interrupts.

Top module: `ret_stack`

## Requirements
- R1: After an asynchronous reset the pointer is 4'hF, the interrupt enable is 0, all entries are 0, and a read of the control register at address 0x10 returns 0x0F.
- R2: A push stores `push_pc_i` into entry `sp[2:0]` and decrements the pointer by one at the same clock edge.
- R3: `pop_pc_o` shows entry `(sp+1)[2:0]` combinationally. A pop without a push increments the pointer by one at the clock edge. After a push, the popped value equals the pushed value.
- R4: The pointer wraps modulo 16 in both directions without any flag. A ninth consecutive push overwrites the entry written by the first push.
- R5: When push and pop are asserted in the same cycle, the pop is ignored. The entry is written and the pointer decrements as for a push alone.
- R6: Control register at address 0x10: bits 3:0 hold the pointer and bit 7 holds the interrupt enable (1 = enabled). Bits 6:4 read as 0, and writes to them have no effect.
- R7: A bus write to address 0x10 loads the pointer and the interrupt enable. It takes priority over a push or pop in the same cycle, although the push still stores its entry.
- R8: The entry window covers addresses 0x00 to 0x0F. Address 2k reads PC bits 7:0 of entry k. Address 2k+1 reads PC bits 11:8 of entry k in bits 3:0, with bits 7:4 reading 0.
- R9: A bus write into the entry window updates the addressed byte of that entry. If a push targets the same entry in the same cycle, the push value is stored whole and the bus write is lost.
- R10: Addresses 0x11 to 0x1F read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save request (call or interrupt entry) |
| push_pc_i | input | 12 | Program counter to save |
| pop_i | input | 1 | Restore request (return) |
| pop_pc_o | output | 12 | Address a restore returns |
| reg_wr_i | input | 1 | Register bus write strobe |
| reg_addr_i | input | 5 | Register bus byte address |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Register bus read data (combinational) |
| sp_o | output | 4 | Current stack pointer |
| gie_o | output | 1 | Global interrupt enable |

## Verification
Nested push and pop runs check LIFO ordering and that a pop hands back what the last push stored. Ten pushes in a row past the eighth level separate correct modulo-16 wrapping from saturation or overflow trapping. Collisions in a single cycle set push against pop, pointer load against push, and a bus byte write against a push to the same entry, and each collision shows whether the priority order is correct. A long pseudo-random mix of all requests and addresses is compared every cycle against a behavioural model. It shows up mismatches in byte lanes, in the reserved bits and in the out-of-window addresses.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_DEC,
    PTR_INC,
    PTR_LOAD
  } ptr_op_e;
endpackage

// File: rtl/rs_ptr.sv
module rs_ptr
  import rs_pkg::*;
#(
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ptr_op_e          op_i,
  input  logic [PTR_W-1:0] load_sp_i,
  input  logic             load_gie_i,
  output logic [PTR_W-1:0] sp_o,
  output logic             gie_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_o  <= '1;
      gie_o <= 1'b0;
    end else begin
      unique case (op_i)
        PTR_DEC:  sp_o <= sp_o - PTR_W'(1);
        PTR_INC:  sp_o <= sp_o + PTR_W'(1);
        PTR_LOAD: begin
          sp_o  <= load_sp_i;
          gie_o <= load_gie_i;
        end
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/rs_mem.sv
module rs_mem
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 12,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned HI_W  = PC_W - BYTE_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        push_i,
  input  logic [IDX_W-1:0]            push_idx_i,
  input  logic [PC_W-1:0]             push_pc_i,
  input  logic                        bus_we_i,
  input  logic [IDX_W-1:0]            bus_idx_i,
  input  logic                        bus_hi_i,
  input  logic [BYTE_W-1:0]           bus_wdata_i,
  output logic [DEPTH-1:0][PC_W-1:0]  ent_o
);
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic hit_push, hit_bus;
    assign hit_push = push_i && (push_idx_i == IDX_W'(k));
    assign hit_bus  = bus_we_i && (bus_idx_i == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_o[k] <= '0;
      end else if (hit_push) begin
        ent_o[k] <= push_pc_i;  // push owns the whole entry
      end else if (hit_bus) begin
        if (bus_hi_i) ent_o[k][PC_W-1:BYTE_W] <= bus_wdata_i[HI_W-1:0];
        else          ent_o[k][BYTE_W-1:0]    <= bus_wdata_i;
      end
    end
  end
endmodule

// File: rtl/rs_rdmux.sv
module rs_rdmux
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PC_W   = 12,
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned HI_W  = PC_W - BYTE_W,
  localparam int unsigned WIN   = 2 * DEPTH
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DEPTH-1:0][PC_W-1:0]  ent_i,
  input  logic [PTR_W-1:0]            sp_i,
  input  logic                        gie_i,
  output logic [BYTE_W-1:0]           rdata_o
);
  logic [IDX_W-1:0] idx;
  assign idx = addr_i[IDX_W:1];

  always_comb begin
    rdata_o = '0;
    if (addr_i < ADDR_W'(WIN)) begin
      if (addr_i[0]) rdata_o[HI_W-1:0] = ent_i[idx][PC_W-1:BYTE_W];
      else           rdata_o           = ent_i[idx][BYTE_W-1:0];
    end else if (addr_i == ADDR_W'(WIN)) begin
      rdata_o = {gie_i, {(BYTE_W-1-PTR_W){1'b0}}, sp_i};
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rs_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PC_W   = 12,
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PC_W-1:0]   push_pc_i,
  input  logic              pop_i,
  output logic [PC_W-1:0]   pop_pc_o,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic              gie_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam int unsigned WIN   = 2 * DEPTH;

  ptr_op_e                   ptr_op;
  logic                      ptr_wr, win_wr;
  logic [IDX_W-1:0]          push_idx, pop_idx;
  logic [DEPTH-1:0][PC_W-1:0] ent;

  assign ptr_wr = reg_wr_i && (reg_addr_i == ADDR_W'(WIN));
  assign win_wr = reg_wr_i && (reg_addr_i <  ADDR_W'(WIN));

  always_comb begin
    if (ptr_wr)      ptr_op = PTR_LOAD;
    else if (push_i) ptr_op = PTR_DEC;
    else if (pop_i)  ptr_op = PTR_INC;
    else             ptr_op = PTR_HOLD;
  end

  assign push_idx = sp_o[IDX_W-1:0];
  assign pop_idx  = IDX_W'(sp_o + PTR_W'(1));

  rs_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_i       (ptr_op),
    .load_sp_i  (reg_wdata_i[PTR_W-1:0]),
    .load_gie_i (reg_wdata_i[BYTE_W-1]),
    .sp_o       (sp_o),
    .gie_o      (gie_o)
  );

  rs_mem #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .push_idx_i  (push_idx),
    .push_pc_i   (push_pc_i),
    .bus_we_i    (win_wr),
    .bus_idx_i   (reg_addr_i[IDX_W:1]),
    .bus_hi_i    (reg_addr_i[0]),
    .bus_wdata_i (reg_wdata_i),
    .ent_o       (ent)
  );

  rs_rdmux #(.DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_rd (
    .addr_i  (reg_addr_i),
    .ent_i   (ent),
    .sp_i    (sp_o),
    .gie_i   (gie_o),
    .rdata_o (reg_rdata_o)
  );

  assign pop_pc_o = ent[pop_idx];
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned PC_W   = 12,
  parameter int unsigned PTR_W  = 4,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              push_i,
  input logic [PC_W-1:0]   push_pc_i,
  input logic              pop_i,
  input logic [PC_W-1:0]   pop_pc_o,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rdata_o,
  input logic [PTR_W-1:0]  sp_o,
  input logic              gie_o
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(2 * DEPTH);
  localparam int unsigned HI_W = PC_W - 8;

  logic ld;
  assign ld = reg_wr_i && (reg_addr_i == CTRL_A);

  p_push_dec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !ld) |=> sp_o == PTR_W'($past(sp_o) - PTR_W'(1)));

  p_push_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !ld) |=> pop_pc_o == $past(push_pc_i));

  p_pop_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !ld) |=> sp_o == PTR_W'($past(sp_o) + PTR_W'(1)));

  p_push_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !ld) |=> sp_o == PTR_W'($past(sp_o) - PTR_W'(1)));

  p_ctrl_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == CTRL_A) |-> reg_rdata_o[6:4] == 3'b000);

  p_ptr_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (sp_o == $past(reg_wdata_i[PTR_W-1:0])) && (gie_o == $past(reg_wdata_i[7])));

  p_gie_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> $stable(gie_o));

  p_hi_pad_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i < CTRL_A && reg_addr_i[0]) |-> reg_rdata_o[7:HI_W] == '0);

  p_oob_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i > CTRL_A) |-> reg_rdata_o == 8'h00);
endmodule

bind ret_stack ret_stack_chk #(
  .DEPTH(DEPTH), .PC_W(PC_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_pc_i(push_pc_i),
  .pop_i(pop_i), .pop_pc_o(pop_pc_o), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sp_o(sp_o), .gie_o(gie_o)
);

// File: tb/tb_ret_stack.sv
`timescale 1ns/1ps
module tb_ret_stack;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        push_i = 1'b0;
  logic [11:0] push_pc_i = '0;
  logic        pop_i = 1'b0;
  logic [11:0] pop_pc_o;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic [3:0]  sp_o;
  logic        gie_o;

  always #2.5 clk_i = ~clk_i;

  ret_stack dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push_i), .push_pc_i(push_pc_i),
    .pop_i(pop_i), .pop_pc_o(pop_pc_o), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sp_o(sp_o), .gie_o(gie_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural model
  int m_sp;
  bit m_gie;
  int m_ent [8];

  function automatic int exp_rd(int a);
    if (a < 16) return (a % 2) ? ((m_ent[a / 2] >> 8) & 'hF) : (m_ent[a / 2] & 'hFF);
    if (a == 16) return (m_gie ? 128 : 0) + m_sp;
    return 0;
  endfunction

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    chk("sp", int'(sp_o), m_sp);
    chk("gie", int'(gie_o), int'(m_gie));
    chk("pop_pc", int'(pop_pc_o), m_ent[(m_sp + 1) % 8]);
    chk("rdata", int'(reg_rdata_o), exp_rd(int'(reg_addr_i)));
  endtask

  task automatic model_update(bit pu, bit pp, int pc, bit wr, int a, int d);
    if (wr && a < 16) begin
      if (a % 2) m_ent[a / 2] = (m_ent[a / 2] & 'h0FF) | ((d & 'hF) << 8);
      else       m_ent[a / 2] = (m_ent[a / 2] & 'hF00) | (d & 'hFF);
    end
    if (pu) m_ent[m_sp % 8] = pc & 'hFFF;
    if (wr && a == 16) begin
      m_sp  = d & 'hF;
      m_gie = (d & 'h80) != 0;
    end else if (pu) m_sp = (m_sp + 15) % 16;
    else if (pp)     m_sp = (m_sp + 1) % 16;
  endtask

  task automatic step(bit pu, bit pp, int pc, bit wr, int a, int d);
    push_i = pu; pop_i = pp; push_pc_i = 12'(pc);
    reg_wr_i = wr; reg_addr_i = 5'(a); reg_wdata_i = 8'(d);
    #1;
    check_all();
    @(posedge clk_i);
    model_update(pu, pp, pc, wr, a, d);
    @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int lfsr = 'hACE1;
    m_sp = 15; m_gie = 0;
    for (int i = 0; i < 8; i++) m_ent[i] = 0;

    // R1 reset state
    cur_req = "R1";
    @(negedge clk_i);
    reg_addr_i = 5'h10; #1;
    check_all();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(0, 0, 0, 0, 16, 0);

    // R2/R3 nested push then pop
    cur_req = "R2";
    step(1, 0, 'h123, 0, 30, 0);
    step(1, 0, 'hABC, 0, 28, 0);
    step(1, 0, 'h3F5, 0, 16, 0);
    cur_req = "R3";
    step(0, 1, 0, 0, 12, 0);
    step(0, 1, 0, 0, 13, 0);
    step(0, 1, 0, 0, 16, 0);
    step(0, 0, 0, 0, 16, 0);

    // R4 wrap through ten pushes and back
    cur_req = "R4";
    for (int i = 0; i < 10; i++) step(1, 0, 'h100 + i * 17, 0, 16, 0);
    for (int i = 0; i < 12; i++) step(0, 1, 0, 0, (i * 2 + 1) % 16, 0);

    // R5 push and pop together
    cur_req = "R5";
    step(1, 1, 'h777, 0, 16, 0);
    step(0, 0, 0, 0, 16, 0);

    // R6 reserved bits and gie
    cur_req = "R6";
    step(0, 0, 0, 1, 16, 'hF5);
    step(0, 0, 0, 0, 16, 0);
    step(0, 0, 0, 1, 16, 'h7A);
    step(0, 0, 0, 0, 16, 0);

    // R7 pointer load against push and pop
    cur_req = "R7";
    step(1, 0, 'h5A5, 1, 16, 'h8F);
    step(0, 1, 0, 1, 16, 'h03);
    step(0, 0, 0, 0, 6, 0);

    // R8 / R9 byte writes in the window
    cur_req = "R8";
    step(0, 0, 0, 1, 4, 'h3C);
    step(0, 0, 0, 1, 5, 'hFE);
    step(0, 0, 0, 0, 5, 0);
    step(0, 0, 0, 0, 4, 0);
    cur_req = "R9";
    step(0, 0, 0, 1, 16, 'h0F);
    step(1, 0, 'hDEF, 1, 14, 'h11);
    step(0, 0, 0, 0, 14, 0);
    step(1, 0, 'h246, 1, 2, 'h99);
    step(0, 1, 0, 0, 2, 0);
    step(0, 0, 0, 0, 3, 0);

    // R10 out-of-window addresses
    cur_req = "R10";
    for (int a = 17; a < 32; a++) step(0, 0, 0, 1, a, 'hFF);
    step(0, 0, 0, 0, 16, 0);
    step(0, 0, 0, 0, 0, 0);

    // pseudo-random mix
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      for (int b = 0; b < 16; b++) lfsr = ((lfsr >> 1) | (((lfsr ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 'hFFFF;
      step((lfsr & 3) == 0, (lfsr & 12) == 0, (lfsr * 7) & 'hFFF,
           (lfsr & 'h70) == 0, (lfsr >> 7) & 'h1F, (lfsr >> 4) & 'hFF);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule